// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block forms the full-width product of two unsigned operands by repeated conditional addition and right shift. One multiplier bit is consumed each clock cycle. The block holds an accumulator above a multiplier register, and a separate register keeps the multiplicand. When the low bit of the multiplier register is one, the multiplicand is added into the accumulator, and the carry out of that addition is kept as an extra top bit. The whole chain of carry, accumulator and multiplier register then moves right by one place. After as many cycles as the operand width, the double-width product sits in the accumulator and multiplier registers taken together.

A client presents both operands with a one-cycle start request while the block is idle. It then waits for the single-cycle completion strobe, and the product is valid from that strobe onward. The product stays on the output until the next accepted request. A request raised while a multiplication is running is dropped. The client can issue a new request in the same cycle as the completion strobe.

Top module: `shift_add_mul`

## Requirements
- R1: After a synchronous active-low reset, busy_o and done_o are 0 and product_o is all zeros.
- R2: A start_i sampled high at a rising edge while busy_o is 0 captures mcand_i and mplier_i, and busy_o is 1 in the next cycle.
- R3: done_o is high for exactly one cycle. It rises WIDTH rising edges after the edge that accepted the request and stays low in every cycle in between.
- R4: In the cycle done_o is high, product_o (2*WIDTH bits, unsigned) equals mcand_i times mplier_i as captured at the accepting edge. This holds for every operand pair, including all-ones times all-ones, and for the directed case 11 times 13 giving 143.
- R5: While busy_o is 0 and no request is accepted, product_o holds its last value.
- R6: A start_i that is high while busy_o is 1 has no effect. The running product, its completion cycle and the held result are unchanged.
- R7: A zero operand on either side gives a zero product, and an operand of one gives the other operand unchanged.
- R8: busy_o is 0 in the cycle done_o is high, so a request in that cycle is accepted and starts a new multiplication without a gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request to begin a multiplication; honoured only when idle |
| mcand_i | input | WIDTH | Multiplicand, sampled with an accepted request |
| mplier_i | input | WIDTH | Multiplier, sampled with an accepted request |
| busy_o | output | 1 | High while a multiplication is in progress |
| done_o | output | 1 | One-cycle strobe marking a valid product |
| product_o | output | 2*WIDTH | Unsigned product, held until the next accepted request |

## Verification
The bench targets the all-ones operand pair, where each addition produces a carry. A design that dropped the carry bit instead of shifting it into the accumulator would return a product that is short in its upper half. Zero and unit operands, and the 11 by 13 case, expose a misplaced shift of the low accumulator bit into the multiplier register. A start pulse raised mid-run would corrupt the result or move the completion strobe if the busy guard were missing. Back-to-back requests in the strobe cycle catch an off-by-one in the cycle counter, which would show up as a late strobe or a lost request.

// File: rtl/mul_pkg.sv
// Shared helpers for the shift-add multiplier.
// Assumes: widths are positive integers known at elaboration.
package mul_pkg;

    // Bits needed to hold a step count from 0 up to and including steps.
    function automatic int count_bits(input int steps);
        return (steps < 1) ? 1 : $clog2(steps + 1);
    endfunction

endpackage

// File: rtl/mul_step.sv
// One iteration of the shift-add loop, purely combinational.
// Adds the multiplicand when the multiplier LSB is set (carry kept as an
// extra top bit), then shifts carry:acc:mplier right by one place.
// Assumes: the carry above acc is zero on entry (it is cleared every shift).
module mul_step #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] acc_i,
    input  logic [WIDTH-1:0] mpl_i,
    input  logic [WIDTH-1:0] mcd_i,
    output logic [WIDTH-1:0] acc_o,
    output logic [WIDTH-1:0] mpl_o
);

    logic [WIDTH:0] sum;   // carry:acc after the conditional add
    logic [WIDTH:0] addend;

    // Select the multiplicand or zero depending on the multiplier LSB.
    always_comb begin
        addend = mpl_i[0] ? {1'b0, mcd_i} : '0;
        sum    = {1'b0, acc_i} + addend;
    end

    // Right shift: carry enters acc MSB, acc LSB enters mplier MSB.
    always_comb begin
        acc_o = sum[WIDTH:1];
        mpl_o = {sum[0], mpl_i[WIDTH-1:1]};
    end

endmodule

// File: rtl/mul_ctrl.sv
// Sequencer for the multiplier: accepts a request when idle, counts WIDTH
// step cycles down to zero, and emits a one-cycle done strobe.
// Assumes: synchronous active-low reset; requests while busy are dropped.
module mul_ctrl #(
    parameter int WIDTH = 8,
    parameter int CW    = mul_pkg::count_bits(WIDTH)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic load_o,
    output logic step_o,
    output logic busy_o,
    output logic done_o
);

    logic [CW-1:0] remain_q;
    logic          busy_q;
    logic          done_q;

    // A request is taken only while idle.
    assign load_o = start_i && !busy_q;
    assign step_o = busy_q;
    assign busy_o = busy_q;
    assign done_o = done_q;

    // Count remaining steps and raise done as the last one completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
            busy_q   <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (load_o) begin
                remain_q <= CW'(WIDTH);
                busy_q   <= 1'b1;
            end else if (busy_q) begin
                remain_q <= remain_q - CW'(1);
                if (remain_q == CW'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/mul_datapath.sv
// Register file of the multiplier: accumulator, multiplier and multiplicand.
// Loads operands on load_i and applies one shift-add step per step_i.
// Assumes: load_i and step_i are never high together (guaranteed by control).
module mul_datapath #(
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic               step_i,
    input  logic [WIDTH-1:0]   mcand_i,
    input  logic [WIDTH-1:0]   mplier_i,
    output logic [2*WIDTH-1:0] product_o
);

    logic [WIDTH-1:0] acc_q, mpl_q, mcd_q;
    logic [WIDTH-1:0] acc_nxt, mpl_nxt;

    mul_step #(.WIDTH(WIDTH)) u_step (
        .acc_i (acc_q),
        .mpl_i (mpl_q),
        .mcd_i (mcd_q),
        .acc_o (acc_nxt),
        .mpl_o (mpl_nxt)
    );

    // Operand capture on load, otherwise one iteration per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            mpl_q <= '0;
            mcd_q <= '0;
        end else if (load_i) begin
            acc_q <= '0;
            mpl_q <= mplier_i;
            mcd_q <= mcand_i;
        end else if (step_i) begin
            acc_q <= acc_nxt;
            mpl_q <= mpl_nxt;
        end
    end

    // The product is assembled in place across acc and mplier.
    assign product_o = {acc_q, mpl_q};

endmodule

// File: rtl/shift_add_mul.sv
// Top of the sequential unsigned multiplier: one multiplier bit per cycle,
// WIDTH cycles per product, result held until the next accepted request.
// Assumes: synchronous active-low reset; operands valid with start_i.
module shift_add_mul #(
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [WIDTH-1:0]   mcand_i,
    input  logic [WIDTH-1:0]   mplier_i,
    output logic               busy_o,
    output logic               done_o,
    output logic [2*WIDTH-1:0] product_o
);

    localparam int CW = mul_pkg::count_bits(WIDTH);

    logic load, step;

    mul_ctrl #(.WIDTH(WIDTH), .CW(CW)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .load_o  (load),
        .step_o  (step),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    mul_datapath #(.WIDTH(WIDTH)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .step_i    (step),
        .mcand_i   (mcand_i),
        .mplier_i  (mplier_i),
        .product_o (product_o)
    );

endmodule

// File: rtl/shift_add_mul_checker.sv
// Property checker for shift_add_mul, attached by bind below.
// Keeps its own latency counter and operand capture to judge the outputs.
module shift_add_mul_checker #(
    parameter int WIDTH = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic [WIDTH-1:0]   mcand_i,
    input logic [WIDTH-1:0]   mplier_i,
    input logic               busy_o,
    input logic               done_o,
    input logic [2*WIDTH-1:0] product_o
);

    localparam int LW = $clog2(WIDTH + 1) + 1;

    logic [LW-1:0]      run_cnt;
    logic [WIDTH-1:0]   cap_a, cap_b;
    logic [2*WIDTH-1:0] want;

    // Track cycles spent busy and the operands of the accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
            cap_a   <= '0;
            cap_b   <= '0;
        end else if (start_i && !busy_o) begin
            run_cnt <= '0;
            cap_a   <= mcand_i;
            cap_b   <= mplier_i;
        end else if (busy_o) begin
            run_cnt <= run_cnt + LW'(1);
        end
    end

    assign want = (2*WIDTH)'(cap_a) * (2*WIDTH)'(cap_b);

    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);  // R2
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);  // R3
    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (run_cnt == LW'(WIDTH)));  // R3
    AST_IDLE_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> !done_o);  // R3
    AST_PRODUCT_OK: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (product_o == want));  // R4
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(product_o));  // R5
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);  // R8

endmodule

bind shift_add_mul shift_add_mul_checker #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .mcand_i   (mcand_i),
    .mplier_i  (mplier_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .product_o (product_o)
);

// File: tb/shift_add_mul_tb.sv
`timescale 1ns/1ps
// Bench for shift_add_mul: directed corners plus seeded random operands,
// expected products computed by a bench function.
module shift_add_mul_tb;

    localparam int W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [W-1:0]     mcand_i = '0;
    logic [W-1:0]     mplier_i = '0;
    logic             busy_o, done_o;
    logic [2*W-1:0]   product_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    shift_add_mul #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .mcand_i(mcand_i), .mplier_i(mplier_i),
        .busy_o(busy_o), .done_o(done_o), .product_o(product_o)
    );

    always #2.5 clk = ~clk;

    function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [2*W-1:0] acc = '0;
        for (int i = 0; i < W; i++)
            if (b[i]) acc = acc + ((2*W)'(a) << i);
        return acc;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called just after an edge; returns just after the edge that raises done.
    // If poke is set, a start with other operands is raised mid-run (R6).
    task automatic do_mul(input logic [W-1:0] a, input logic [W-1:0] b, input bit poke);
        logic [2*W-1:0] exp = ref_mul(a, b);
        start_i = 1'b1; mcand_i = a; mplier_i = b;
        @(posedge clk); #1;
        start_i = 1'b0; mcand_i = ~a; mplier_i = ~b;
        check(busy_o == 1'b1, "R2 busy after start", busy_o, 1);
        for (int i = 1; i < W; i++) begin
            if (poke && i == 2) start_i = 1'b1;
            if (poke && i == 3) start_i = 1'b0;
            @(posedge clk); #1;
            check(done_o == 1'b0, "R3 done early", done_o, 0);
        end
        @(posedge clk); #1;
        check(done_o == 1'b1, "R3 done on time", done_o, 1);
        check(busy_o == 1'b0, "R8 idle at done", busy_o, 0);
        check(product_o == exp, poke ? "R6 product after ignored start" : "R4 product",
              product_o, exp);
        if (a == 0 || b == 0 || a == 1 || b == 1)
            check(product_o == exp, "R7 zero/unit operand", product_o, exp);
    endtask

    // One idle cycle after done: strobe gone and result held.
    task automatic idle_check(input int n);
        logic [2*W-1:0] held = product_o;
        for (int i = 0; i < n; i++) begin
            start_i = 1'b0;
            mcand_i = W'($urandom); mplier_i = W'($urandom);
            @(posedge clk); #1;
            check(done_o == 1'b0, "R3 single-cycle done", done_o, 0);
            check(product_o == held, "R5 product held", product_o, held);
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(posedge clk);
        #1;
        check(busy_o == 1'b0, "R1 reset busy", busy_o, 0);
        check(done_o == 1'b0, "R1 reset done", done_o, 0);
        check(product_o == '0, "R1 reset product", product_o, 0);
        rst_n = 1'b1;
        @(posedge clk); #1;

        do_mul(8'd11, 8'd13, 1'b0);   // R4 directed 143
        check(product_o == 16'd143, "R4 11x13", product_o, 143);
        idle_check(2);
        do_mul(8'hFF, 8'hFF, 1'b0);   // R4 carry on every add
        idle_check(1);
        do_mul(8'd0, 8'hA5, 1'b0);    // R7
        idle_check(1);
        do_mul(8'h5A, 8'd0, 1'b0);    // R7
        idle_check(1);
        do_mul(8'd1, 8'hC3, 1'b0);    // R7
        idle_check(1);
        do_mul(8'h80, 8'd2, 1'b0);
        idle_check(1);
        do_mul(8'h37, 8'h91, 1'b1);   // R6 start mid-run ignored
        idle_check(3);
        do_mul(8'h12, 8'h34, 1'b0);   // R8 back-to-back requests
        do_mul(8'hFE, 8'h81, 1'b0);
        do_mul(8'h01, 8'h01, 1'b0);
        idle_check(1);

        for (int n = 0; n < 60; n++) begin
            do_mul(W'($urandom), W'($urandom), ($urandom % 5) == 0);
            if ($urandom % 2) idle_check(1 + ($urandom % 3));
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule